// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by following a tree of page tables kept in an external memory. A caller hands it a virtual address together with the physical page number of the top-level table. The walker then reads one table entry per level through a request/response memory port. At each level it uses one slice of the virtual page number to pick the entry. Each entry it fetches either names the next, lower table or gives the final page mapping.

The walk ends in one of two ways. On success the block pulses `done` for one cycle and presents the physical address, which is the final page number placed above the untouched page offset. On failure it pulses `fault` and reports the level where the walk stopped. Only one walk is in flight at a time. The block takes a new request only while it is idle, and the memory may take any number of cycles to answer.

With the default parameters the virtual address is 16 bits wide. The page offset is 8 bits, for 256-byte pages, and there are two levels of 4 index bits each. Table entries are 16 bits, two bytes each.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, and `done`, `fault` and `mem_req_valid` are 0.
- R2: A request is taken only on a cycle when `req_valid` and `req_ready` are both 1. `req_ready` is 1 only while idle. Requests presented during a walk are ignored and do not change its result.
- R3: The entry for level L is read at byte address (table_ppn << 8) + index_L * 2. Level 0 uses the table given by `req_root_ppn` and index bits [15:12] of the virtual address. Level 1 uses the table named by the level-0 entry and index bits [11:8].
- R4: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. At most one read is outstanding, and the walker waits any number of cycles for `mem_rsp_valid`.
- R5: Entry format: bit 15 is valid, bit 14 is leaf (final mapping), bits 13:8 are ignored, and bits 7:0 are the physical page number.
- R6: A valid leaf at the last level ends the walk with a one-cycle `done` and `paddr` = {entry[7:0], vaddr[7:0]}.
- R7: An entry with the valid bit clear ends the walk with a one-cycle `fault`, and `fault_level` gives that level (0 = top). No further reads are issued.
- R8: A valid leaf found above the last level is a fault at that level.
- R9: A valid non-leaf entry at the last level is a fault at the last level.
- R10: `done` and `fault` are never high together, each lasts exactly one cycle, and `req_ready` returns the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 16 | Virtual address to translate |
| req_root_ppn | input | 8 | Page number of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 16 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 16 | Fetched table entry |
| done | output | 1 | One-cycle pulse on successful translation |
| fault | output | 1 | One-cycle pulse on failed translation |
| fault_level | output | 1 | Level where the walk failed |
| paddr | output | 16 | Translated physical address, valid with `done` |

## Verification
Two things can happen in the same cycle: a walk completing and a new request waiting at the input. The bench holds `req_valid` high without a break from the start of one walk. Partway through, it changes the address and root to a second translation. It then checks three things. First, the first walk still returns its own physical address. Second, `req_ready` is low in the cycle `done` pulses. Third, the waiting request is taken only after the walker has returned to idle, and it yields the second translation. Random-looking ready and response delays from the memory model also place response arrival next to request hold-off, to exercise R4.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_DONE  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_e;

  function automatic int unsigned lvl_width(input int unsigned levels);
    return (levels > 1) ? $clog2(levels) : 1;
  endfunction

endpackage

// File: rtl/pt_walker_idx_sel.sv
module pt_walker_idx_sel #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned VA_W   = OFF_W + LEVELS * IDX_W,
  parameter int unsigned LVL_W  = 1
) (
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);

  logic [IDX_W-1:0] field [LEVELS];

  // level 0 takes the most significant slice of the page number
  for (genvar l = 0; l < LEVELS; l++) begin : g_field
    assign field[l] = vaddr[OFF_W + (LEVELS - 1 - l) * IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx = field[l];
    end
  end

endmodule

// File: rtl/pt_walker_addr_gen.sv
module pt_walker_addr_gen #(
  parameter int unsigned PPN_W     = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned PTE_BYTES = 2,
  parameter int unsigned PA_W      = PPN_W + OFF_W
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);

  localparam int unsigned SHIFT = (PTE_BYTES > 1) ? $clog2(PTE_BYTES) : 0;

  logic [PA_W-1:0] table_base;
  logic [PA_W-1:0] entry_off;

  assign table_base = {base_ppn, {OFF_W{1'b0}}};
  assign entry_off  = PA_W'(idx) << SHIFT;
  assign addr       = table_base + entry_off;

endmodule

// File: rtl/pt_walker_fsm.sv
module pt_walker_fsm
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned PTE_W  = 16,
  parameter int unsigned VA_W   = OFF_W + LEVELS * IDX_W,
  parameter int unsigned PA_W   = PPN_W + OFF_W,
  parameter int unsigned LVL_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PPN_W-1:0] req_root_ppn,
  output logic             req_ready,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic [LVL_W-1:0] cur_level,
  output logic [PPN_W-1:0] cur_base,
  output logic [VA_W-1:0]  cur_vaddr,
  output logic             done,
  output logic             fault,
  output logic [LVL_W-1:0] fault_level,
  output logic [PA_W-1:0]  paddr
);

  localparam int unsigned VLD_BIT  = PTE_W - 1;
  localparam int unsigned LEAF_BIT = PTE_W - 2;

  walk_state_e      state_q, state_nx;
  logic [LVL_W-1:0] lvl_q;
  logic [PPN_W-1:0] base_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  pa_q;

  logic             pte_vld, pte_leaf, last_lvl;
  logic [PPN_W-1:0] pte_ppn;
  logic             unused_rsv;
  logic             accept_en, descend_en, finish_en;

  assign pte_vld    = mem_rsp_data[VLD_BIT];
  assign pte_leaf   = mem_rsp_data[LEAF_BIT];
  assign pte_ppn    = mem_rsp_data[PPN_W-1:0];
  assign unused_rsv = ^mem_rsp_data[LEAF_BIT-1:PPN_W];
  assign last_lvl   = (lvl_q == LVL_W'(LEVELS - 1));

  // clock enables for the datapath registers
  assign accept_en  = (state_q == ST_IDLE) && req_valid;
  assign descend_en = (state_q == ST_WAIT) && mem_rsp_valid && pte_vld &&
                      !pte_leaf && !last_lvl;
  assign finish_en  = (state_q == ST_WAIT) && mem_rsp_valid && pte_vld &&
                      pte_leaf && last_lvl;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid) state_nx = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) state_nx = ST_WAIT;
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (!pte_vld)      state_nx = ST_FAULT;
          else if (pte_leaf) state_nx = last_lvl ? ST_DONE : ST_FAULT;
          else               state_nx = last_lvl ? ST_FAULT : ST_ISSUE;
        end
      end
      ST_DONE:  state_nx = ST_IDLE;
      ST_FAULT: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      base_q <= '0;
      va_q   <= '0;
    end else if (accept_en) begin
      lvl_q  <= '0;
      base_q <= req_root_ppn;
      va_q   <= req_vaddr;
    end else if (descend_en) begin
      lvl_q  <= lvl_q + LVL_W'(1);
      base_q <= pte_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pa_q <= '0;
    else if (finish_en) pa_q <= {pte_ppn, va_q[OFF_W-1:0]};
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign done          = (state_q == ST_DONE);
  assign fault         = (state_q == ST_FAULT);
  assign fault_level   = lvl_q;
  assign paddr         = pa_q;
  assign cur_level     = lvl_q;
  assign cur_base      = base_q;
  assign cur_vaddr     = va_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned LEVELS = 2,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned OFF_W  = 8,
  parameter int unsigned PPN_W  = 8,
  parameter int unsigned PTE_W  = 16,
  localparam int unsigned VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int unsigned PA_W  = PPN_W + OFF_W,
  localparam int unsigned LVL_W = pt_walker_pkg::lvl_width(LEVELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [PPN_W-1:0] req_root_ppn,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [LVL_W-1:0] fault_level,
  output logic [PA_W-1:0]  paddr
);

  localparam int unsigned PTE_BYTES = PTE_W / 8;

  logic [LVL_W-1:0] cur_level;
  logic [PPN_W-1:0] cur_base;
  logic [VA_W-1:0]  cur_vaddr;
  logic [IDX_W-1:0] cur_idx;

  pt_walker_fsm #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
    .PTE_W(PTE_W), .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_root_ppn (req_root_ppn),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data (mem_rsp_data),
    .cur_level    (cur_level),
    .cur_base     (cur_base),
    .cur_vaddr    (cur_vaddr),
    .done         (done),
    .fault        (fault),
    .fault_level  (fault_level),
    .paddr        (paddr)
  );

  pt_walker_idx_sel #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .VA_W(VA_W), .LVL_W(LVL_W)
  ) u_idx (
    .vaddr(cur_vaddr),
    .level(cur_level),
    .idx  (cur_idx)
  );

  pt_walker_addr_gen #(
    .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
    .PTE_BYTES(PTE_BYTES), .PA_W(PA_W)
  ) u_addr (
    .base_ppn(cur_base),
    .idx     (cur_idx),
    .addr    (mem_req_addr)
  );

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              done,
  input logic              fault
);

  p_no_read_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_aligned_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[0] == 1'b0));

  p_done_after_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_rsp_valid));

  p_fault_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(mem_rsp_valid));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_one_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> (!done && !fault && req_ready));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(PA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .mem_rsp_valid(mem_rsp_valid),
  .done         (done),
  .fault        (fault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_vaddr;
  logic [7:0]  req_root_ppn;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        done;
  logic        fault;
  logic [0:0]  fault_level;
  logic [15:0] paddr;

  int n_chk;
  int n_fail;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_root_ppn(req_root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .fault(fault),
    .fault_level(fault_level), .paddr(paddr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural memory: 16-bit words, byte address bits [11:1]
  logic [15:0] mem [0:2047];
  logic [15:0] rd_log [0:1023];
  int          rd_cnt;
  int          rdy_delay;
  int          rsp_lat;
  int          wcnt;
  int          rcnt;
  logic        pend;
  logic [15:0] lat_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      wcnt          <= 0;
      rcnt          <= 0;
      pend          <= 1'b0;
      lat_addr      <= '0;
      rd_cnt        <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_ready  <= 1'b0;
        wcnt           <= rdy_delay;
        pend           <= 1'b1;
        rcnt           <= rsp_lat;
        lat_addr       <= mem_req_addr;
        rd_log[rd_cnt] <= mem_req_addr;
        rd_cnt         <= rd_cnt + 1;
      end else if (mem_req_valid) begin
        if (wcnt == 0) mem_req_ready <= 1'b1;
        else           wcnt <= wcnt - 1;
      end
      if (pend) begin
        if (rcnt == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mem[lat_addr[11:1]];
          pend          <= 1'b0;
        end else begin
          rcnt <= rcnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent model of the walk from the requirement text
  task automatic ref_walk(input logic [15:0] va, input logic [7:0] root,
                          output bit flt, output int lvl, output logic [15:0] pa,
                          output int nrd, output logic [15:0] a0, output logic [15:0] a1);
    logic [7:0]  base;
    logic [15:0] addr;
    logic [15:0] pte;
    logic [3:0]  idx;
    base = root; flt = 0; lvl = 0; pa = '0; nrd = 0; a0 = '0; a1 = '0;
    for (int l = 0; l < 2; l++) begin
      idx  = (l == 0) ? va[15:12] : va[11:8];
      addr = {base, 8'h00} + {11'd0, idx, 1'b0};
      if (l == 0) a0 = addr; else a1 = addr;
      nrd++;
      pte = mem[addr[11:1]];
      if (!pte[15]) begin flt = 1; lvl = l; return; end
      if (pte[14]) begin
        if (l == 0) begin flt = 1; lvl = l; end
        else pa = {pte[7:0], va[7:0]};
        return;
      end
      if (l == 1) begin flt = 1; lvl = l; return; end
      base = pte[7:0];
    end
  endtask

  task automatic start_req(input logic [15:0] va, input logic [7:0] root);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid    = 1'b1;
    req_vaddr    = va;
    req_root_ppn = root;
    @(negedge clk);
    chk(req_ready == 1'b0, "R2", "ready low after accept", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b0;
  endtask

  task automatic wait_result(output bit ok);
    int guard;
    guard = 0;
    ok = 1;
    while (!(done || fault)) begin
      @(negedge clk);
      guard++;
      if (guard > 400) begin
        ok = 0;
        chk(1'b0, "R4", "walk timeout", 32'd0, 32'd1);
        return;
      end
    end
  endtask

  task automatic run_vec(input logic [15:0] va, input logic [7:0] root);
    bit          eflt;
    int          elvl;
    logic [15:0] epa;
    int          enrd;
    logic [15:0] ea0;
    logic [15:0] ea1;
    int          start;
    bit          ok;
    ref_walk(va, root, eflt, elvl, epa, enrd, ea0, ea1);
    start = rd_cnt;
    start_req(va, root);
    wait_result(ok);
    if (!ok) return;
    if (eflt) begin
      chk(fault && !done, "R7", "fault pulse", {30'd0, fault, done}, 32'd2);
      chk(fault_level == elvl[0:0], "R8", "fault level", {31'd0, fault_level}, elvl);
    end else begin
      chk(done && !fault, "R6", "done pulse", {30'd0, done, fault}, 32'd2);
      chk(paddr == epa, "R6", "physical address", {16'd0, paddr}, {16'd0, epa});
    end
    chk(rd_cnt - start == enrd, "R7", "read count", rd_cnt - start, enrd);
    chk(rd_log[start] == ea0, "R3", "level0 entry address", {16'd0, rd_log[start]}, {16'd0, ea0});
    if (enrd > 1)
      chk(rd_log[start+1] == ea1, "R3", "level1 entry address",
          {16'd0, rd_log[start+1]}, {16'd0, ea1});
    @(negedge clk);
    chk(!done && !fault && req_ready, "R10", "single pulse then idle",
        {29'd0, done, fault, req_ready}, 32'd1);
  endtask

  // {vaddr, root ppn, ready delay, response latency}
  localparam logic [31:0] VEC [12] = '{
    {16'h0012, 8'h01, 4'd0, 4'd0},
    {16'h05AB, 8'h01, 4'd2, 4'd1},
    {16'h0FFF, 8'h01, 4'd0, 4'd5},
    {16'h0700, 8'h01, 4'd1, 4'd0},
    {16'h1234, 8'h01, 4'd3, 4'd2},
    {16'h2300, 8'h01, 4'd0, 4'd3},
    {16'h0955, 8'h01, 4'd4, 4'd0},
    {16'h3F80, 8'h01, 4'd1, 4'd4},
    {16'hF433, 8'h01, 4'd0, 4'd1},
    {16'h0F01, 8'h06, 4'd2, 4'd2},
    {16'h0F01, 8'h01, 4'd5, 4'd0},
    {16'h3000, 8'h01, 4'd0, 4'd0}
  };

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    bit ok;
    n_chk = 0; n_fail = 0;
    rdy_delay = 0; rsp_lat = 0;
    req_valid = 1'b0; req_vaddr = '0; req_root_ppn = '0;
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
    // top table at page 1 (words 0x80..)
    mem[11'h080] = 16'h8002;
    mem[11'h082] = 16'hC005;   // leaf above last level
    mem[11'h083] = 16'h8003;
    mem[11'h08F] = 16'h8003;
    // second table set at page 2 (words 0x100..)
    mem[11'h100] = 16'hC040;
    mem[11'h105] = 16'hC07A;
    mem[11'h109] = 16'h8004;   // pointer at last level
    mem[11'h10F] = 16'hC0FF;
    // second table at page 3 (words 0x180..)
    mem[11'h180] = 16'hC011;
    mem[11'h184] = 16'hFF22;   // reserved bits set
    mem[11'h18F] = 16'hC0EE;
    // alternate top table at page 6 (words 0x300..)
    mem[11'h300] = 16'h8003;

    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !fault && !mem_req_valid, "R1", "reset state",
        {28'd0, req_ready, done, fault, mem_req_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req_valid, "R1", "idle after reset release",
        {30'd0, req_ready, mem_req_valid}, 32'h2);

    for (int v = 0; v < 12; v++) begin
      rdy_delay = int'(VEC[v][7:4]);
      rsp_lat   = int'(VEC[v][3:0]);
      run_vec(VEC[v][31:16], VEC[v][15:8]);   // R4 under varied delays
    end

    // directed literal expectations
    rdy_delay = 1; rsp_lat = 2;
    start_req(16'hF433, 8'h01);
    wait_result(ok);
    chk(done && paddr == 16'h2233, "R5", "reserved bits ignored", {16'd0, paddr}, 32'h2233);
    start_req(16'h2300, 8'h01);
    wait_result(ok);
    chk(fault && fault_level == 1'b0, "R8", "early leaf faults at level 0",
        {30'd0, fault, fault_level}, 32'h2);
    start_req(16'h0955, 8'h01);
    wait_result(ok);
    chk(fault && fault_level == 1'b1, "R9", "pointer at last level faults",
        {30'd0, fault, fault_level}, 32'h3);

    // request held high through a walk and its completion
    rdy_delay = 2; rsp_lat = 3;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = 16'h05AB; req_root_ppn = 8'h01;
    @(negedge clk);
    req_vaddr = 16'h0F01; req_root_ppn = 8'h06;
    wait_result(ok);
    chk(done && paddr == 16'h7AAB, "R2", "busy request ignored", {16'd0, paddr}, 32'h7AAB);
    chk(!req_ready, "R10", "not ready during done", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    chk(req_ready && !done, "R10", "ready after done", {30'd0, req_ready, done}, 32'h2);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2", "held request taken from idle", {31'd0, req_ready}, 32'd0);
    wait_result(ok);
    chk(done && paddr == 16'hEE01, "R2", "second walk result", {16'd0, paddr}, 32'hEE01);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule